// File: doc/BRIEF.md
# Stack Push Execution Unit

This unit performs a single stack push. It takes a source value and its kind, an operand width and a stack-pointer width, and then works out four results: the decremented stack pointer, the write address, the extended store data, and the byte strobes that limit the store to the bytes it owns. When the push completes, a one-cycle write request and a pointer update leave the unit on the next clock edge.

Outside 64-bit mode, each push is checked against the stack-segment limit. A push that would leave the segment changes nothing, neither the pointer nor memory, and reports a stack fault instead. In real mode, a small tracker counts faults that follow each other with no successful push in between. The second such fault becomes a double fault, and the third puts the unit into a shutdown state that only reset clears.

The unit also provides a combinational source-address adder for memory operands. This adder always uses the stack pointer as it was before the decrement.

Top module: `spush_unit`

## Requirements
- R1: When `push_vld` is sampled high, the following edge raises `wr_en` and `sp_wr` for one cycle. `wr_addr` then holds the pointer decremented by 2, 4 or 8, and `sp_out` holds the new pointer. Size codes are 0 = 16-bit, 1 = 32-bit, and 2 or 3 = 64-bit. When `push_vld` is low, no write, update or fault appears on the next edge.
- R2: The stack-width code selects which low 16, 32 or 64 pointer bits are decremented and wrap. Bits above that width pass to `sp_out` unchanged, and `wr_addr` holds only the low bits.
- R3: When `long_mode` is 1, the unit treats the stack width as 64 whatever `stk_sz` says, and it skips the limit check.
- R4: A source of kind 1 (immediate) is sign-extended before it is stored. Its width code is 0 = 8, 1 = 16 or 2 = 32 bits. The result is then cut to the operand width. A kind 0 (register or memory) source is cut to the operand width without extension.
- R5: For a source of kind 2 (segment register), the low 16 bits are zero-extended. With a 64-bit operand, all 8 strobes are set. With a 32-bit operand, only strobes [1:0] are set, so the upper two bytes of the slot are left as they were.
- R6: A source of kind 3 (the stack pointer) stores the pointer from before the decrement, masked to the stack width.
- R7: `src_addr` equals `src_disp` plus either the pre-decrement `sp_cur` (when `src_base_sp` is 1) or `src_base`.
- R8: Outside `long_mode`, a push raises a fault when new address + size − 1 exceeds `ss_limit`. Such a push raises neither `wr_en` nor `sp_wr`. A push whose last byte lands exactly on the limit is allowed.
- R9: In real mode, the first fault raises `ss_fault`. A second fault with no successful push in between raises `df_fault`. A third fault raises `shutdown` and produces neither fault pulse.
- R10: `shutdown` stays high until reset. While it is high, pushes produce no write, no update and no fault.
- R11: A successful push returns the fault chain to its start. Faults outside real mode always raise `ss_fault` and never escalate.
- R12: A push narrower than the stack width may leave a pointer that is not a multiple of the stack width. This is accepted without a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_vld | input | 1 | Start a push this cycle |
| src_kind | input | 2 | 0 register/memory, 1 immediate, 2 segment, 3 stack pointer |
| imm_sz | input | 2 | Immediate width: 0 = 8, 1 = 16, 2 = 32 bits |
| op_sz | input | 2 | Operand width code |
| stk_sz | input | 2 | Stack-pointer width code |
| long_mode | input | 1 | 64-bit mode |
| real_mode | input | 1 | Real mode (enables fault escalation) |
| sp_cur | input | 64 | Current stack pointer |
| ss_limit | input | 64 | Stack-segment limit |
| src_value | input | 64 | Source operand value |
| src_base | input | 64 | Base register for a memory source |
| src_disp | input | 64 | Displacement for a memory source |
| src_base_sp | input | 1 | Memory source is based on the stack pointer |
| src_addr | output | 64 | Memory source address |
| wr_en | output | 1 | Write request |
| wr_addr | output | 64 | Write address |
| wr_data | output | 64 | Write data, byte 0 at `wr_addr` |
| wr_strb | output | 8 | Byte enables relative to `wr_addr` |
| sp_wr | output | 1 | Stack pointer update valid |
| sp_out | output | 64 | Updated stack pointer |
| ss_fault | output | 1 | Stack fault pulse |
| df_fault | output | 1 | Double fault pulse |
| shutdown | output | 1 | Shutdown state, held until reset |

## Verification
The bench builds the unit with the package defaults: a 64-bit pointer and data path with eight byte lanes. At this width, 16-, 32- and 64-bit stack widths can all be exercised against one another, including wrap of a 16-bit pointer under a nonzero upper half and a 64-bit operand over a 16-bit stack code in long mode. The same width also allows a limit of all ones next to small limits, so both a fault and a write landing exactly on the limit can be observed.

// File: rtl/spush_pkg.sv
`timescale 1ns/1ps
package spush_pkg;

    localparam int XLEN   = 64;
    localparam int NBYTE  = XLEN / 8;
    localparam int CNT_W  = $clog2(NBYTE) + 1;

    typedef enum logic [1:0] {
        SRC_REG = 2'd0,
        SRC_IMM = 2'd1,
        SRC_SEG = 2'd2,
        SRC_SP  = 2'd3
    } src_kind_e;

    typedef enum logic [1:0] {
        ESC_IDLE = 2'd0,
        ESC_SS   = 2'd1,
        ESC_DF   = 2'd2,
        ESC_SHUT = 2'd3
    } esc_e;

    typedef struct packed {
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] sp_next;
        logic            fault;
    } ptr_res_t;

    typedef struct packed {
        logic [XLEN-1:0]  data;
        logic [NBYTE-1:0] strb;
    } wr_fmt_t;

    // Mask of pointer or data bits covered by a width code.
    function automatic logic [XLEN-1:0] span_mask(input logic [1:0] code);
        logic [XLEN-1:0] m;
        case (code)
            2'd0:    m = {{(XLEN-16){1'b0}}, 16'hFFFF};
            2'd1:    m = {{(XLEN-32){1'b0}}, 32'hFFFF_FFFF};
            default: m = '1;
        endcase
        return m;
    endfunction

    // Byte count of a width code.
    function automatic logic [CNT_W-1:0] span_bytes(input logic [1:0] code);
        logic [CNT_W-1:0] n;
        case (code)
            2'd0:    n = CNT_W'(2);
            2'd1:    n = CNT_W'(4);
            default: n = CNT_W'(8);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/spush_ptr.sv
`timescale 1ns/1ps
module spush_ptr
    import spush_pkg::*;
(
    input  logic [XLEN-1:0] sp_cur,
    input  logic [1:0]      op_sz,
    input  logic [1:0]      stk_eff,
    input  logic [XLEN-1:0] limit,
    input  logic            chk_en,
    output ptr_res_t        res
);
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] step;
    logic [XLEN-1:0] dec;
    logic [XLEN:0]   last_byte;

    always_comb begin
        mask      = span_mask(stk_eff);
        step      = XLEN'(span_bytes(op_sz));
        dec       = sp_cur - step;
        res.addr    = dec & mask;
        res.sp_next = (sp_cur & ~mask) | (dec & mask);
        last_byte = {1'b0, res.addr} + {1'b0, step} - (XLEN+1)'(1);
        res.fault = chk_en && (last_byte > {1'b0, limit});
    end
endmodule

// File: rtl/spush_fmt.sv
`timescale 1ns/1ps
module spush_fmt
    import spush_pkg::*;
(
    input  src_kind_e       kind,
    input  logic [1:0]      imm_sz,
    input  logic [1:0]      op_sz,
    input  logic [1:0]      stk_eff,
    input  logic [XLEN-1:0] value,
    input  logic [XLEN-1:0] sp_cur,
    output wr_fmt_t         fmt
);
    logic [XLEN-1:0]  imm_ext;
    logic [XLEN-1:0]  raw;
    logic [CNT_W-1:0] nb;

    always_comb begin
        case (imm_sz)
            2'd0:    imm_ext = {{(XLEN-8){value[7]}},   value[7:0]};
            2'd1:    imm_ext = {{(XLEN-16){value[15]}}, value[15:0]};
            default: imm_ext = {{(XLEN-32){value[31]}}, value[31:0]};
        endcase

        case (kind)
            SRC_IMM: raw = imm_ext;
            SRC_SEG: raw = {{(XLEN-16){1'b0}}, value[15:0]};
            SRC_SP:  raw = sp_cur & span_mask(stk_eff);
            default: raw = value;
        endcase

        fmt.data = raw & span_mask(op_sz);

        nb = span_bytes(op_sz);
        if (kind == SRC_SEG && op_sz == 2'd1)
            nb = CNT_W'(2);
        for (int i = 0; i < NBYTE; i++)
            fmt.strb[i] = (i < int'(nb));
    end
endmodule

// File: rtl/spush_esc.sv
`timescale 1ns/1ps
module spush_esc
    import spush_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic fault,
    input  logic real_md,
    output esc_e state
);
    esc_e nxt;

    always_comb begin
        nxt = state;
        if (take) begin
            if (!fault) begin
                nxt = ESC_IDLE;
            end else if (real_md) begin
                case (state)
                    ESC_IDLE: nxt = ESC_SS;
                    ESC_SS:   nxt = ESC_DF;
                    default:  nxt = ESC_SHUT;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ESC_IDLE;
        else
            state <= nxt;
    end
endmodule

// File: rtl/spush_srcaddr.sv
`timescale 1ns/1ps
module spush_srcaddr
    import spush_pkg::*;
(
    input  logic [XLEN-1:0] sp_pre,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] disp,
    input  logic            use_sp,
    output logic [XLEN-1:0] addr
);
    always_comb addr = (use_sp ? sp_pre : base) + disp;
endmodule

// File: rtl/spush_unit.sv
`timescale 1ns/1ps
module spush_unit
    import spush_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 push_vld,
    input  logic [1:0]           src_kind,
    input  logic [1:0]           imm_sz,
    input  logic [1:0]           op_sz,
    input  logic [1:0]           stk_sz,
    input  logic                 long_mode,
    input  logic                 real_mode,
    input  logic [XLEN-1:0]      sp_cur,
    input  logic [XLEN-1:0]      ss_limit,
    input  logic [XLEN-1:0]      src_value,
    input  logic [XLEN-1:0]      src_base,
    input  logic [XLEN-1:0]      src_disp,
    input  logic                 src_base_sp,
    output logic [XLEN-1:0]      src_addr,
    output logic                 wr_en,
    output logic [XLEN-1:0]      wr_addr,
    output logic [XLEN-1:0]      wr_data,
    output logic [NBYTE-1:0]     wr_strb,
    output logic                 sp_wr,
    output logic [XLEN-1:0]      sp_out,
    output logic                 ss_fault,
    output logic                 df_fault,
    output logic                 shutdown
);
    logic [1:0] stk_eff;
    logic       take;
    ptr_res_t   pres;
    wr_fmt_t    wfmt;
    esc_e       esc_q;

    assign stk_eff  = long_mode ? 2'd2 : stk_sz;
    assign shutdown = (esc_q == ESC_SHUT);
    assign take     = push_vld && !shutdown;

    spush_ptr u_ptr (
        .sp_cur  (sp_cur),
        .op_sz   (op_sz),
        .stk_eff (stk_eff),
        .limit   (ss_limit),
        .chk_en  (!long_mode),
        .res     (pres)
    );

    spush_fmt u_fmt (
        .kind    (src_kind_e'(src_kind)),
        .imm_sz  (imm_sz),
        .op_sz   (op_sz),
        .stk_eff (stk_eff),
        .value   (src_value),
        .sp_cur  (sp_cur),
        .fmt     (wfmt)
    );

    spush_esc u_esc (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .fault   (pres.fault),
        .real_md (real_mode),
        .state   (esc_q)
    );

    spush_srcaddr u_sa (
        .sp_pre  (sp_cur),
        .base    (src_base),
        .disp    (src_disp),
        .use_sp  (src_base_sp),
        .addr    (src_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            wr_strb  <= '0;
            sp_wr    <= 1'b0;
            sp_out   <= '0;
            ss_fault <= 1'b0;
            df_fault <= 1'b0;
        end else begin
            wr_en    <= take && !pres.fault;
            sp_wr    <= take && !pres.fault;
            ss_fault <= take && pres.fault && (!real_mode || esc_q == ESC_IDLE);
            df_fault <= take && pres.fault && real_mode && esc_q == ESC_SS;
            if (take) begin
                if (pres.fault) begin
                    sp_out <= sp_cur;
                end else begin
                    sp_out  <= pres.sp_next;
                    wr_addr <= pres.addr;
                    wr_data <= wfmt.data;
                    wr_strb <= wfmt.strb;
                end
            end
        end
    end
endmodule

// File: rtl/spush_chk.sv
`timescale 1ns/1ps
module spush_chk
    import spush_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             push_vld,
    input logic             wr_en,
    input logic [XLEN-1:0]  wr_addr,
    input logic [NBYTE-1:0] wr_strb,
    input logic             sp_wr,
    input logic [XLEN-1:0]  sp_out,
    input logic             ss_fault,
    input logic             df_fault,
    input logic             shutdown
);
    // R8
    wr_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, ss_fault, df_fault}));

    // R1
    strb_count_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($countones(wr_strb) == 2 || $countones(wr_strb) == 4
                   || $countones(wr_strb) == 8));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !push_vld |=> (!wr_en && !sp_wr && !ss_fault && !df_fault));

    // R8
    wr_sp_pair_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (sp_wr && sp_out[15:0] == wr_addr[15:0]));

    // R10
    shut_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        shutdown |=> shutdown);

    // R10
    shut_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        shutdown |=> (!wr_en && !sp_wr && !ss_fault && !df_fault));
endmodule

bind spush_unit spush_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .push_vld (push_vld),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_strb  (wr_strb),
    .sp_wr    (sp_wr),
    .sp_out   (sp_out),
    .ss_fault (ss_fault),
    .df_fault (df_fault),
    .shutdown (shutdown)
);

// File: tb/sim_spush_unit.sv
`timescale 1ns/1ps
module sim_spush_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        push_vld;
    logic [1:0]  src_kind, imm_sz, op_sz, stk_sz;
    logic        long_mode, real_mode;
    logic [63:0] sp_cur, ss_limit, src_value, src_base, src_disp;
    logic        src_base_sp;
    logic [63:0] src_addr, wr_addr, wr_data, sp_out;
    logic [7:0]  wr_strb;
    logic        wr_en, sp_wr, ss_fault, df_fault, shutdown;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    spush_unit u0 (.*);

    typedef struct packed {
        logic [1:0]  kind, isz, osz, ssz;
        logic        lng, rl;
        logic [63:0] val, sp, lim, e_addr, e_data;
        logic [7:0]  e_strb;
        logic [63:0] e_sp;
        logic        e_flt;
    } vec_t;

    localparam logic [63:0] F = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{2'd0,2'd0,2'd2,2'd2,1'b1,1'b0,64'h1122334455667788,64'h1000,F,64'hFF8,64'h1122334455667788,8'hFF,64'hFF8,1'b0},
        '{2'd1,2'd0,2'd2,2'd2,1'b1,1'b0,64'h80,64'h1000,F,64'hFF8,64'hFFFFFFFFFFFFFF80,8'hFF,64'hFF8,1'b0},
        '{2'd1,2'd2,2'd1,2'd1,1'b0,1'b0,64'h80000000,64'hAAAABBBB00000100,F,64'hFC,64'h80000000,8'h0F,64'hAAAABBBB000000FC,1'b0},
        '{2'd1,2'd0,2'd0,2'd0,1'b0,1'b0,64'h7F,64'h12340000,F,64'hFFFE,64'h7F,8'h03,64'h1234FFFE,1'b0},
        '{2'd2,2'd0,2'd2,2'd2,1'b1,1'b0,64'hDEAD00000000BEEF,64'h2000,F,64'h1FF8,64'hBEEF,8'hFF,64'h1FF8,1'b0},
        '{2'd2,2'd0,2'd1,2'd1,1'b0,1'b0,64'hDEAD00000000BEEF,64'h2000,F,64'h1FFC,64'hBEEF,8'h03,64'h1FFC,1'b0},
        '{2'd3,2'd0,2'd2,2'd2,1'b1,1'b0,64'h0,64'h3008,F,64'h3000,64'h3008,8'hFF,64'h3000,1'b0},
        '{2'd3,2'd0,2'd0,2'd1,1'b0,1'b0,64'h0,64'h10008,F,64'h10006,64'h8,8'h03,64'h10006,1'b0},
        '{2'd0,2'd0,2'd2,2'd0,1'b1,1'b0,64'h55,64'h10000,F,64'hFFF8,64'h55,8'hFF,64'hFFF8,1'b0},
        '{2'd0,2'd0,2'd1,2'd1,1'b0,1'b0,64'h1,64'h100,64'hF0,64'h0,64'h0,8'h00,64'h100,1'b1},
        '{2'd0,2'd0,2'd0,2'd1,1'b0,1'b0,64'h12345678,64'h40,64'hFFFF,64'h3E,64'h5678,8'h03,64'h3E,1'b0},
        '{2'd0,2'd0,2'd1,2'd1,1'b0,1'b0,64'hCAFEF00D,64'h44,64'h43,64'h40,64'hCAFEF00D,8'h0F,64'h40,1'b0},
        '{2'd1,2'd1,2'd1,2'd1,1'b0,1'b0,64'h8001,64'h80,F,64'h7C,64'hFFFF8001,8'h0F,64'h7C,1'b0},
        '{2'd0,2'd0,2'd2,2'd2,1'b1,1'b0,64'h9,64'h100,64'h0,64'hF8,64'h9,8'hFF,64'hF8,1'b0},
        '{2'd0,2'd0,2'd0,2'd0,1'b0,1'b0,64'h1,64'h0,F,64'hFFFE,64'h1,8'h03,64'hFFFE,1'b0}
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 10:  return "R1";
            1, 12:  return "R4";
            2:      return "R2/R4";
            3, 14:  return "R2";
            4, 5:   return "R5";
            6:      return "R6";
            7:      return "R6/R12";
            8, 13:  return "R3";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_in(input logic [1:0] k, input logic [1:0] isz, input logic [1:0] osz,
                          input logic [1:0] ssz, input logic lng, input logic rl,
                          input logic [63:0] v, input logic [63:0] sp, input logic [63:0] lim);
        src_kind = k; imm_sz = isz; op_sz = osz; stk_sz = ssz;
        long_mode = lng; real_mode = rl; src_value = v; sp_cur = sp; ss_limit = lim;
    endtask

    // Pulse push_vld for one cycle; returns at the negedge after the capturing edge.
    task automatic pulse();
        @(negedge clk);
        push_vld = 1'b1;
        @(negedge clk);
        push_vld = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; push_vld = 1'b0; src_base = '0; src_disp = '0; src_base_sp = 1'b0;
        set_in(2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, '0, '0, F);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(!wr_en && !sp_wr && !ss_fault && !df_fault && !shutdown, "R1",
              {59'd0, wr_en, sp_wr, ss_fault, df_fault, shutdown}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            set_in(VEC[i].kind, VEC[i].isz, VEC[i].osz, VEC[i].ssz, VEC[i].lng, VEC[i].rl,
                   VEC[i].val, VEC[i].sp, VEC[i].lim);
            pulse();
            if (VEC[i].e_flt) begin
                check(!wr_en && !sp_wr && ss_fault, tag_of(i),
                      {61'd0, wr_en, sp_wr, ss_fault}, 64'h1);
            end else begin
                check(wr_en && sp_wr, tag_of(i), {62'd0, wr_en, sp_wr}, 64'h3);
                check(wr_addr == VEC[i].e_addr, tag_of(i), wr_addr, VEC[i].e_addr);
                check(wr_data == VEC[i].e_data, tag_of(i), wr_data, VEC[i].e_data);
                check(wr_strb == VEC[i].e_strb, tag_of(i), {56'd0, wr_strb}, {56'd0, VEC[i].e_strb});
                check(sp_out == VEC[i].e_sp, tag_of(i), sp_out, VEC[i].e_sp);
            end
        end

        // R1 no request: outputs quiet
        @(negedge clk);
        check(!wr_en && !sp_wr, "R1", {62'd0, wr_en, sp_wr}, 64'h0);

        // R7 source address uses the pre-decrement pointer
        sp_cur = 64'h100; src_disp = 64'h8; src_base = 64'h2000; src_base_sp = 1'b1;
        #1;
        check(src_addr == 64'h108, "R7", src_addr, 64'h108);
        src_base_sp = 1'b0;
        #1;
        check(src_addr == 64'h2008, "R7", src_addr, 64'h2008);

        // R11 faults outside real mode never escalate
        set_in(2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 64'h1, 64'h1, 64'hFFFF);
        pulse();
        check(ss_fault && !df_fault, "R11", {62'd0, ss_fault, df_fault}, 64'h2);
        pulse();
        check(ss_fault && !df_fault, "R11", {62'd0, ss_fault, df_fault}, 64'h2);

        // R9 real-mode chain with SP = 1
        set_in(2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 64'h1, 64'h1, 64'hFFFF);
        pulse();
        check(ss_fault && !df_fault && !wr_en && !sp_wr, "R9",
              {61'd0, ss_fault, df_fault, wr_en}, 64'h4);
        pulse();
        check(!ss_fault && df_fault && !wr_en, "R9",
              {61'd0, ss_fault, df_fault, wr_en}, 64'h2);
        pulse();
        check(shutdown && !ss_fault && !df_fault && !wr_en, "R9",
              {60'd0, shutdown, ss_fault, df_fault, wr_en}, 64'h8);

        // R10 shutdown ignores a valid push and holds
        sp_cur = 64'h10;
        pulse();
        check(shutdown && !wr_en && !sp_wr && !ss_fault, "R10",
              {60'd0, shutdown, wr_en, sp_wr, ss_fault}, 64'h8);
        repeat (3) @(negedge clk);
        check(shutdown, "R10", {63'd0, shutdown}, 64'h1);

        // R10 only reset clears shutdown
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!shutdown, "R10", {63'd0, shutdown}, 64'h0);

        // R11 a success restarts the chain
        sp_cur = 64'h1;
        pulse();
        check(ss_fault, "R11", {63'd0, ss_fault}, 64'h1);
        sp_cur = 64'h10;
        pulse();
        check(wr_en && wr_addr == 64'hE, "R11", wr_addr, 64'hE);
        sp_cur = 64'h1;
        pulse();
        check(ss_fault && !df_fault, "R11", {62'd0, ss_fault, df_fault}, 64'h2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule